// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small accumulator-based processor. It holds carry, zero, interrupt mask, decimal mode, memory-to-memory mode, overflow and negative. The ALU and data-transfer paths, the decoded flag commands, a bit-test operand, a status pull from the stack and the two interrupt-entry strobes all update it. Every update takes effect at the next rising clock edge.

The block also provides three outputs:

- the live byte image of the flags;
- a gate that tells the interrupt controller whether maskable requests may be taken;
- the byte to push onto the stack on interrupt entry.

The break marker is never stored in the live register. It appears only in the byte pushed during a software-break entry. The arithmetic itself, the stack memory and instruction decoding are outside the block.

Top module: `psr_top`

## Requirements
- R1: A synchronous active-high reset sets the interrupt mask and clears every other flag, so `status_byte` reads 8'h04. The bit layout of both bytes, from bit 7 down to bit 0, is: negative, overflow, memory mode, break, decimal, interrupt mask, zero, carry.
- R2: `irq_allow` is 1 exactly when the interrupt mask flag is 0.
- R3: A pulse on `irq_enter` or `brk_enter` sets the interrupt mask at the next edge. In that cycle every other flag holds its value.
- R4: `status_byte` bit 4 always reads 0. `push_byte` equals the live flags, with bit 4 equal to `brk_enter` in the same cycle.
- R5: When `cmd_valid` is 1, `cmd_code` acts on one flag:
  - 0 sets carry, 1 clears carry;
  - 2 sets the mask, 3 clears the mask;
  - 4 sets decimal, 5 clears decimal;
  - 6 sets memory mode, 7 clears memory mode;
  - 8 clears overflow;
  - codes 9 to 15 change nothing.
- R6: With `res_we`, zero is loaded with (`res_value` == 0) and negative with `res_value[7]`.
- R7: With `carry_we`, carry loads `carry_in`. With `ovf_we`, overflow loads `ovf_in`.
- R8: With `bit_test`, negative loads `bit_operand[7]` and overflow loads `bit_operand[6]`. This overrides `res_we` and `ovf_we` on those two flags.
- R9: With `pull_we`, every flag loads the same-numbered bit of `pull_data`, except bit 4, which stays 0.
- R10: The update sources rank as follows:
  - reset first;
  - then interrupt entry;
  - then pull;
  - then commands;
  - then datapath updates (R6 to R8).
  
  Where a command names a flag, it overrides a datapath write to that flag in the same cycle. Other flags still take their datapath updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carry_we | input | 1 | Carry write enable (arithmetic, shift, rotate) |
| carry_in | input | 1 | New carry value |
| ovf_we | input | 1 | Overflow write enable |
| ovf_in | input | 1 | New overflow value |
| res_we | input | 1 | Result or transfer value valid for zero/negative |
| res_value | input | 8 | Result or transferred byte |
| bit_test | input | 1 | Bit-test operation strobe |
| bit_operand | input | 8 | Memory operand of the bit test |
| cmd_valid | input | 1 | Flag command valid |
| cmd_code | input | 4 | Flag command code (R5) |
| pull_we | input | 1 | Status restore strobe |
| pull_data | input | 8 | Byte pulled from the stack |
| irq_enter | input | 1 | Maskable interrupt entry strobe |
| brk_enter | input | 1 | Software break entry strobe |
| status_byte | output | 8 | Live flag image, bit 4 always 0 |
| push_byte | output | 8 | Image for the stack push |
| irq_allow | output | 1 | Maskable interrupts may be taken |

## Verification
The datapath path is driven with a zero result, a result with bit 7 set and a small positive result, which separates the zero and negative updates. Bit-test operands 8'hC0 and 8'h40 are applied with a conflicting result write in the same cycle, which shows that the two operand bits land in separate flags and take priority. The command codes are stepped through both directions on each flag, and the unused codes are applied to a byte with every flag set, which exposes any stray decode. Collision cycles combine:
- entry with pull;
- pull with a command;
- a command with a datapath write to the same flag.

Each combination separates one rank of the priority order.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int WORD_W  = 8;
    localparam int CODE_W  = 4;
    localparam int POS_C   = 0;
    localparam int POS_Z   = 1;
    localparam int POS_I   = 2;
    localparam int POS_D   = 3;
    localparam int POS_B   = 4;
    localparam int POS_T   = 5;
    localparam int POS_V   = 6;
    localparam int POS_N   = 7;

    typedef struct packed {
        logic n;
        logic v;
        logic t;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [CODE_W-1:0] {
        CMD_C_SET = 4'd0,
        CMD_C_CLR = 4'd1,
        CMD_I_SET = 4'd2,
        CMD_I_CLR = 4'd3,
        CMD_D_SET = 4'd4,
        CMD_D_CLR = 4'd5,
        CMD_T_SET = 4'd6,
        CMD_T_CLR = 4'd7,
        CMD_V_CLR = 4'd8
    } cmd_code_e;

    typedef struct packed {
        logic set_c;
        logic clr_c;
        logic set_i;
        logic clr_i;
        logic set_d;
        logic clr_d;
        logic set_t;
        logic clr_t;
        logic clr_v;
    } cmd_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, t: 1'b0, d: 1'b0,
                                       i: 1'b1, z: 1'b0, c: 1'b0};

    function automatic logic [WORD_W-1:0] pack_flags(flags_t f, logic brk);
        logic [WORD_W-1:0] b;
        b        = '0;
        b[POS_C] = f.c;
        b[POS_Z] = f.z;
        b[POS_I] = f.i;
        b[POS_D] = f.d;
        b[POS_B] = brk;
        b[POS_T] = f.t;
        b[POS_V] = f.v;
        b[POS_N] = f.n;
        return b;
    endfunction

    function automatic flags_t unpack_flags(logic [WORD_W-1:0] b);
        flags_t f;
        f.c = b[POS_C];
        f.z = b[POS_Z];
        f.i = b[POS_I];
        f.d = b[POS_D];
        f.t = b[POS_T];
        f.v = b[POS_V];
        f.n = b[POS_N];
        return f;
    endfunction

endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
    import psr_pkg::*;
(
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output cmd_t              cmd
);
    always_comb begin
        cmd = '0;
        if (valid) begin
            case (code)
                CMD_C_SET: cmd.set_c = 1'b1;
                CMD_C_CLR: cmd.clr_c = 1'b1;
                CMD_I_SET: cmd.set_i = 1'b1;
                CMD_I_CLR: cmd.clr_i = 1'b1;
                CMD_D_SET: cmd.set_d = 1'b1;
                CMD_D_CLR: cmd.clr_d = 1'b1;
                CMD_T_SET: cmd.set_t = 1'b1;
                CMD_T_CLR: cmd.clr_t = 1'b1;
                CMD_V_CLR: cmd.clr_v = 1'b1;
                default:   cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/psr_next.sv
module psr_next
    import psr_pkg::*;
(
    input  flags_t              cur,
    input  logic                entry,
    input  logic                pull_we,
    input  logic [WORD_W-1:0]   pull_data,
    input  cmd_t                cmd,
    input  logic                carry_we,
    input  logic                carry_in,
    input  logic                ovf_we,
    input  logic                ovf_in,
    input  logic                res_we,
    input  logic [WORD_W-1:0]   res_value,
    input  logic                bit_test,
    input  logic [WORD_W-1:0]   bit_operand,
    output flags_t              nxt
);
    flags_t dp;

    // Datapath layer: result, carry/overflow writes, bit test on top.
    always_comb begin
        dp = cur;
        if (carry_we) dp.c = carry_in;
        if (ovf_we)   dp.v = ovf_in;
        if (res_we) begin
            dp.z = (res_value == '0);
            dp.n = res_value[WORD_W-1];
        end
        if (bit_test) begin
            dp.n = bit_operand[POS_N];
            dp.v = bit_operand[POS_V];
        end
    end

    // Ranking: entry, pull, command, datapath.
    always_comb begin
        nxt = dp;
        if (entry) begin
            nxt   = cur;
            nxt.i = 1'b1;
        end else if (pull_we) begin
            nxt = unpack_flags(pull_data);
        end else begin
            if (cmd.set_c) nxt.c = 1'b1;
            if (cmd.clr_c) nxt.c = 1'b0;
            if (cmd.set_i) nxt.i = 1'b1;
            if (cmd.clr_i) nxt.i = 1'b0;
            if (cmd.set_d) nxt.d = 1'b1;
            if (cmd.clr_d) nxt.d = 1'b0;
            if (cmd.set_t) nxt.t = 1'b1;
            if (cmd.clr_t) nxt.t = 1'b0;
            if (cmd.clr_v) nxt.v = 1'b0;
        end
    end
endmodule

// File: rtl/psr_image.sv
module psr_image
    import psr_pkg::*;
(
    input  flags_t              flags,
    input  logic                brk_enter,
    output logic [WORD_W-1:0]   live_byte,
    output logic [WORD_W-1:0]   stack_byte,
    output logic                allow
);
    assign live_byte  = pack_flags(flags, 1'b0);
    assign stack_byte = pack_flags(flags, brk_enter);
    assign allow      = ~flags.i;
endmodule

// File: rtl/psr_top.sv
module psr_top
    import psr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                carry_we,
    input  logic                carry_in,
    input  logic                ovf_we,
    input  logic                ovf_in,
    input  logic                res_we,
    input  logic [7:0]          res_value,
    input  logic                bit_test,
    input  logic [7:0]          bit_operand,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_code,
    input  logic                pull_we,
    input  logic [7:0]          pull_data,
    input  logic                irq_enter,
    input  logic                brk_enter,
    output logic [7:0]          status_byte,
    output logic [7:0]          push_byte,
    output logic                irq_allow
);
    flags_t flags_q;
    flags_t flags_d;
    cmd_t   cmd;
    logic   entry;

    assign entry = irq_enter | brk_enter;

    psr_cmd_decode u_dec (
        .valid (cmd_valid),
        .code  (cmd_code),
        .cmd   (cmd)
    );

    psr_next u_next (
        .cur         (flags_q),
        .entry       (entry),
        .pull_we     (pull_we),
        .pull_data   (pull_data),
        .cmd         (cmd),
        .carry_we    (carry_we),
        .carry_in    (carry_in),
        .ovf_we      (ovf_we),
        .ovf_in      (ovf_in),
        .res_we      (res_we),
        .res_value   (res_value),
        .bit_test    (bit_test),
        .bit_operand (bit_operand),
        .nxt         (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAGS_RESET;
        else     flags_q <= flags_d;
    end

    psr_image u_img (
        .flags      (flags_q),
        .brk_enter  (brk_enter),
        .live_byte  (status_byte),
        .stack_byte (push_byte),
        .allow      (irq_allow)
    );

    // R1: reset leaves the mask set
    a_r1_reset_mask: assert property (@(posedge clk) rst |=> status_byte == 8'h04);
    // R3: entry sets the mask and leaves carry alone
    a_r3_entry_mask: assert property (@(posedge clk) disable iff (rst)
        (irq_enter || brk_enter) |=> status_byte[POS_I]);
    a_r3_entry_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_enter || brk_enter) |=> $stable(status_byte[POS_C]));
    // R9: pull loads all but break
    a_r9_pull_load: assert property (@(posedge clk) disable iff (rst)
        (pull_we && !irq_enter && !brk_enter) |=> status_byte == ($past(pull_data) & 8'hEF));
    // R8: bit test loads negative
    a_r8_bit_neg: assert property (@(posedge clk) disable iff (rst)
        (bit_test && !pull_we && !irq_enter && !brk_enter) |=> status_byte[POS_N] == $past(bit_operand[POS_N]));
    // R5: overflow clear command
    a_r5_clr_v: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'd8 && !pull_we && !irq_enter && !brk_enter) |=> !status_byte[POS_V]);
endmodule

// File: tb/psr_top_bench.sv
module psr_top_bench;
    logic clk = 1'b0;
    logic rst;
    logic carry_we, carry_in, ovf_we, ovf_in, res_we, bit_test;
    logic cmd_valid, pull_we, irq_enter, brk_enter;
    logic [7:0] res_value, bit_operand, pull_data;
    logic [3:0] cmd_code;
    logic [7:0] status_byte, push_byte;
    logic irq_allow;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    psr_top u_psr_top (
        .clk(clk), .rst(rst), .carry_we(carry_we), .carry_in(carry_in),
        .ovf_we(ovf_we), .ovf_in(ovf_in), .res_we(res_we), .res_value(res_value),
        .bit_test(bit_test), .bit_operand(bit_operand), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .pull_we(pull_we), .pull_data(pull_data),
        .irq_enter(irq_enter), .brk_enter(brk_enter), .status_byte(status_byte),
        .push_byte(push_byte), .irq_allow(irq_allow)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; carry_we = 0; carry_in = 0; ovf_we = 0; ovf_in = 0;
        res_we = 0; res_value = 0; bit_test = 0; bit_operand = 0;
        cmd_valid = 0; cmd_code = 0; pull_we = 0; pull_data = 0;
        irq_enter = 0; brk_enter = 0;
    endtask

    // inputs set after a falling edge; one rising edge; sample at next falling edge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic pull(logic [7:0] v);
        pull_we = 1; pull_data = v; step();
    endtask

    task automatic cmd(logic [3:0] c);
        cmd_valid = 1; cmd_code = c; step();
    endtask

    task automatic t_reset();
        rst = 1; step(); step();
        check("R1 reset", status_byte, 8'h04);
        check("R2 masked", {7'd0, irq_allow}, 8'h00);
    endtask

    task automatic t_commands();
        pull(8'h00);
        check("R2 unmasked", {7'd0, irq_allow}, 8'h01);
        cmd(4'd0); cmd(4'd2); cmd(4'd4); cmd(4'd6);
        check("R5 sets", status_byte, 8'h2D);
        cmd(4'd1); cmd(4'd3);
        check("R5 clear c,i", status_byte, 8'h28);
        cmd(4'd5); cmd(4'd7);
        check("R5 clear d,t", status_byte, 8'h00);
        pull(8'hFF);
        for (int k = 9; k < 16; k++) cmd(k[3:0]);
        check("R5 unused codes", status_byte, 8'hEF);
        cmd(4'd8);
        check("R5 clear v", status_byte, 8'hAF);
    endtask

    task automatic t_result();
        pull(8'h00);
        res_we = 1; res_value = 8'h00; step();
        check("R6 zero", status_byte, 8'h02);
        res_we = 1; res_value = 8'h80; step();
        check("R6 negative", status_byte, 8'h80);
        res_we = 1; res_value = 8'h05; step();
        check("R6 positive", status_byte, 8'h00);
    endtask

    task automatic t_carry_ovf();
        pull(8'h00);
        carry_we = 1; carry_in = 1; ovf_we = 1; ovf_in = 1; step();
        check("R7 set c,v", status_byte, 8'h41);
        carry_we = 1; carry_in = 0; step();
        check("R7 clear c only", status_byte, 8'h40);
    endtask

    task automatic t_bit();
        pull(8'h00);
        bit_test = 1; bit_operand = 8'hC0; res_we = 1; res_value = 8'h01; step();
        check("R8 c0", status_byte, 8'hC0);
        bit_test = 1; bit_operand = 8'h40; ovf_we = 1; ovf_in = 0; step();
        check("R8 40", status_byte, 8'h40);
    endtask

    task automatic t_entry();
        pull(8'hC3);
        irq_enter = 1; #1;
        check("R4 push irq", push_byte, 8'hC3);
        check("R4 live b", status_byte, 8'hC3);
        carry_we = 1; carry_in = 0; step();
        check("R3 irq entry", status_byte, 8'hC7);
        pull(8'h01);
        brk_enter = 1; #1;
        check("R4 push brk", push_byte, 8'h11);
        step();
        check("R3 brk entry", status_byte, 8'h05);
    endtask

    task automatic t_pull_prio();
        pull(8'hFF);
        check("R9 pull ff", status_byte, 8'hEF);
        pull(8'h10);
        check("R9 pull b dropped", status_byte, 8'h00);
        irq_enter = 1; pull_we = 1; pull_data = 8'hF0; step();
        check("R10 entry over pull", status_byte, 8'h04);
        pull_we = 1; pull_data = 8'h00; cmd_valid = 1; cmd_code = 4'd0; step();
        check("R10 pull over cmd", status_byte, 8'h00);
        cmd_valid = 1; cmd_code = 4'd0; carry_we = 1; carry_in = 0;
        res_we = 1; res_value = 8'h00; step();
        check("R10 cmd over carry", status_byte, 8'h03);
        pull(8'h00);
        cmd_valid = 1; cmd_code = 4'd8; ovf_we = 1; ovf_in = 1; step();
        check("R10 cmd over v", status_byte, 8'h00);
    endtask

    initial begin
        idle();
        rst = 1;
        t_reset();
        t_commands();
        t_result();
        t_carry_ovf();
        t_bit();
        t_entry();
        t_pull_prio();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule